// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a small up-counter that steps through straight binary values on each rising clock edge. It can be cleared at any moment by an active-low clear input. On a clock edge it can instead take a new value from a set of preset inputs, under an active-low load control. It counts only when two separate count-enable inputs are both high.

A terminal-count output goes high when the counter sits at its all-ones value. That output is qualified by only one of the two enables, the carry enable. Because of this, several instances can be chained into one wider counter that stays fully synchronous, with no ripple from one stage to the next. To chain them, each stage's terminal count drives the carry enable of the next stage. The first stage's carry enable is tied high, and one shared signal drives the count enable of every stage.

The width is a parameter, with a default of 4 bits.

Top module: `sync_bin_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 at once, without waiting for a clock edge, and `tc` is low. Clear overrides load and count.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `preset` after that edge.
- R3: A load happens whatever the values of `cnt_en` and `carry_en`, including when both are low.
- R4: When `load_n`, `cnt_en` and `carry_en` are all high at a rising edge, `q` increases by one.
- R5: When `load_n` is high and either `cnt_en` or `carry_en` is low at a rising edge, `q` keeps its value.
- R6: When counting is enabled, an edge at the all-ones value (15 for 4 bits) wraps `q` to 0.
- R7: `tc` is high exactly when `q` is all ones and `carry_en` is high. It follows its inputs combinationally and does not depend on `cnt_en`.
- R8: `tc` is low whenever `carry_en` is low.
- R9: When stages are chained (each `tc` feeding the next stage's `carry_en`, the first stage's `carry_en` tied high, one shared `cnt_en`), the chain counts as a single binary counter of the combined width. The last stage's `tc` is high only at the combined all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable; gates counting only |
| carry_en | input | 1 | Count enable that also qualifies `tc` |
| preset | input | WIDTH | Value loaded when `load_n` is low |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal count (carry) |

## Verification
The only state is the count register, and it is always visible on `q`. A wrong next-state choice therefore shows on `q` one edge after the stimulus that caused it: a missed load, a count taken while an enable was low, or a hold where an increment was due. A fault in the carry logic shows on `tc` at once, but only when the count is at all ones. For that reason the stimulus parks the counter at that value while each enable is toggled. In a chain, a wrong carry in one stage corrupts the combined value on the very next edge. This is checked by comparing the joined outputs with a wide reference count.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    typedef struct packed {
        logic load_n;
        logic cnt_en;
        logic carry_en;
    } ctrl_t;

    // Priority: load first, then count, else hold.
    function automatic op_e pick_op(input ctrl_t c);
        if (!c.load_n)
            return OP_LOAD;
        else if (c.cnt_en && c.carry_en)
            return OP_COUNT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/ctr_mode_decode.sv
module ctr_mode_decode
    import ctr_pkg::*;
(
    input  ctrl_t ctl,
    output op_e   op
);

    always_comb begin
        op = pick_op(ctl);
    end

endmodule

// File: rtl/ctr_state_reg.sv
module ctr_state_reg
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_LOAD:  nxt = preset;
            OP_COUNT: nxt = q + STEP;
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= nxt;
    end

endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             carry_en,
    output logic             tc
);

    logic [WIDTH:0] chain;

    assign chain[0] = carry_en;

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_and
            assign chain[g+1] = chain[g] & q[g];
        end
    endgenerate

    assign tc = chain[WIDTH];

endmodule

// File: rtl/sync_bin_counter.sv
module sync_bin_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             carry_en,
    input  logic [WIDTH-1:0] preset,
    output logic [WIDTH-1:0] q,
    output logic             tc
);

    ctrl_t ctl;
    op_e   op;

    assign ctl = '{load_n: load_n, cnt_en: cnt_en, carry_en: carry_en};

    ctr_mode_decode u_decode (
        .ctl (ctl),
        .op  (op)
    );

    ctr_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk    (clk),
        .clr_n  (clr_n),
        .op     (op),
        .preset (preset),
        .q      (q)
    );

    ctr_carry #(.WIDTH(WIDTH)) u_carry (
        .q        (q),
        .carry_en (carry_en),
        .tc       (tc)
    );

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             cnt_en,
    input logic             carry_en,
    input logic [WIDTH-1:0] preset,
    input logic [WIDTH-1:0] q,
    input logic             tc
);

    localparam logic [WIDTH-1:0] ALL1 = '1;

    p_clear_r1: assert property (@(posedge clk) !clr_n |-> (q == '0 && !tc));

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(preset));

    p_count_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en) |=> q == $past(q) + WIDTH'(1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(q));

    p_wrap_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && carry_en && q == ALL1) |=> q == '0);

    p_tc_full_r7: assert property (@(posedge clk) disable iff (!clr_n)
        tc |-> (q == ALL1));

    p_tc_gate_r8: assert property (@(posedge clk) disable iff (!clr_n)
        !carry_en |-> !tc);

endmodule

bind sync_bin_counter ctr_checker #(.WIDTH(WIDTH)) u_ctr_checker (
    .clk      (clk),
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .carry_en (carry_en),
    .preset   (preset),
    .q        (q),
    .tc       (tc)
);

// File: tb/test_sync_bin_counter.sv
module test_sync_bin_counter;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       carry_en = 1'b0;
    logic [3:0] preset = 4'h0;
    logic [3:0] q;
    logic       tc;

    // three-stage chain
    logic        z_clr_n = 1'b1;
    logic        z_load_n = 1'b1;
    logic        z_en = 1'b0;
    logic [11:0] z_preset = 12'h0;
    logic [3:0]  zq0, zq1, zq2;
    logic        ztc0, ztc1, ztc2;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [3:0]  exp_q = 4'h0;
    logic [11:0] exp_z = 12'h0;

    always #5 clk = ~clk;

    sync_bin_counter #(.WIDTH(4)) i_sync_bin_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
        .carry_en(carry_en), .preset(preset), .q(q), .tc(tc)
    );

    sync_bin_counter #(.WIDTH(4)) i_s0 (
        .clk(clk), .clr_n(z_clr_n), .load_n(z_load_n), .cnt_en(z_en),
        .carry_en(1'b1), .preset(z_preset[3:0]), .q(zq0), .tc(ztc0)
    );
    sync_bin_counter #(.WIDTH(4)) i_s1 (
        .clk(clk), .clr_n(z_clr_n), .load_n(z_load_n), .cnt_en(z_en),
        .carry_en(ztc0), .preset(z_preset[7:4]), .q(zq1), .tc(ztc1)
    );
    sync_bin_counter #(.WIDTH(4)) i_s2 (
        .clk(clk), .clr_n(z_clr_n), .load_n(z_load_n), .cnt_en(z_en),
        .carry_en(ztc1), .preset(z_preset[11:8]), .q(zq2), .tc(ztc2)
    );

    function automatic logic [3:0] model_q(logic [3:0] cur, logic ld_n,
                                           logic ce, logic te, logic [3:0] p);
        if (!ld_n)        return p;
        else if (ce && te) return cur + 4'd1;
        else              return cur;
    endfunction

    function automatic logic model_tc(logic [3:0] cur, logic te);
        return (cur == 4'hF) && te;
    endfunction

    function automatic logic [11:0] model_z(logic [11:0] cur, logic ld_n,
                                            logic en, logic [11:0] p);
        if (!ld_n)  return p;
        else if (en) return cur + 12'd1;
        else        return cur;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [3:0]  nq;
        logic [11:0] nz;
        nq = model_q(exp_q, load_n, cnt_en, carry_en, preset);
        nz = model_z(exp_z, z_load_n, z_en, z_preset);
        @(posedge clk);
        #1;
        exp_q = nq;
        exp_z = nz;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        #1;
        clr_n = 1'b0;
        z_clr_n = 1'b0;
        load_n = 1'b0;
        cnt_en = 1'b1;
        carry_en = 1'b1;
        preset = 4'h9;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset q", q, 4'h0);
        check("R1 reset tc", tc, 1'b0);
        check("R1 reset chain", {zq2, zq1, zq0}, 12'h0);
        clr_n = 1'b1;
        z_clr_n = 1'b1;
        exp_q = 4'h0;
        exp_z = 12'h0;

        // R3: load with both enables low
        load_n = 1'b0; cnt_en = 1'b0; carry_en = 1'b0; preset = 4'hA;
        tick();
        check("R3 load ignores enables", q, exp_q);
        check("R2 load value", q, 4'hA);

        // R5: hold with each enable low
        load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b1;
        tick();
        check("R5 hold cnt_en low", q, 4'hA);
        cnt_en = 1'b1; carry_en = 1'b0;
        tick();
        check("R5 hold carry_en low", q, 4'hA);

        // R4: count
        carry_en = 1'b1;
        tick();
        check("R4 count", q, 4'hB);

        // R7/R8 at all ones
        load_n = 1'b0; preset = 4'hF;
        tick();
        check("R2 load F", q, 4'hF);
        load_n = 1'b1; cnt_en = 1'b0; carry_en = 1'b1;
        #1;
        check("R7 tc with cnt_en low", tc, 1'b1);
        carry_en = 1'b0;
        #1;
        check("R8 tc forced low", tc, 1'b0);
        cnt_en = 1'b1;
        #1;
        check("R8 tc low cnt_en high", tc, 1'b0);

        // R6: wrap
        carry_en = 1'b1;
        tick();
        check("R6 wrap", q, 4'h0);
        check("R7 tc after wrap", tc, 1'b0);

        // R1: clear mid-cycle, no edge, overrides load
        load_n = 1'b0; preset = 4'h7;
        tick();
        check("R2 load 7", q, 4'h7);
        clr_n = 1'b0;
        #1;
        check("R1 async clear", q, 4'h0);
        @(posedge clk);
        #1;
        check("R1 clear beats load", q, 4'h0);
        clr_n = 1'b1;
        exp_q = 4'h0;
        load_n = 1'b1;

        // random single-counter stimulus
        for (int i = 0; i < 400; i++) begin
            load_n   = ($urandom_range(0, 4) != 0);
            cnt_en   = ($urandom_range(0, 3) != 0);
            carry_en = ($urandom_range(0, 3) != 0);
            preset   = 4'($urandom_range(0, 15));
            tick();
            check("R2 R4 R5 random q", q, exp_q);
            check("R7 random tc", tc, model_tc(exp_q, carry_en));
        end

        // R9: chain across a full wrap
        z_load_n = 1'b0; z_preset = 12'hFFD; z_en = 1'b1;
        tick();
        check("R9 chain load", {zq2, zq1, zq0}, 12'hFFD);
        z_load_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            check("R9 chain count", {zq2, zq1, zq0}, exp_z);
            check("R9 chain tc", ztc2, exp_z == 12'hFFF);
        end

        // R9 random chain
        for (int i = 0; i < 600; i++) begin
            z_en     = ($urandom_range(0, 4) != 0);
            z_load_n = ($urandom_range(0, 40) != 0);
            z_preset = 12'($urandom_range(0, 4095));
            tick();
            check("R9 chain random", {zq2, zq1, zq0}, exp_z);
            check("R9 chain random tc", ztc2, exp_z == 12'hFFF);
        end

        finish_run();
    end

endmodule